// File: doc/BRIEF.md
# Ballast Mode Sequencer with Over-Current Fault Counter

This block is the supervisory state machine of a fluorescent lamp ballast controller. It takes digital comparator decisions as inputs: supply above its turn-on level, supply below its turn-off level, shutdown input high, lamp end-of-life window violated, half-bridge over-current, and DC bus under-voltage. It also takes a strobe that is high while the low-side switch is on. From these it steps the ballast through five modes: lockout, filament preheat, ignition, run, and a latched fault. It drives the half-bridge oscillator enable, the power-factor stage enable, and a request to pull the supply down.

Two down-counting timers set how long preheat and ignition last. Their tick counts are taken from input buses, and only while the block is in lockout. Over-current tolerance depends on the mode. During preheat and ignition, a fault needs an unbroken run of over-current events, each seen during a low-side on interval. In run, a single event is enough. A fault stays latched until the supply drops or the shutdown input is raised.

Top module: `ballast_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, mode_o is 0 (lockout), osc_en_o and pfc_en_o are 0 and vcc_dump_o is 0.
- R2: In lockout, vcc_on_i high with sd_hi_i and vcc_off_i low moves the mode to 1 (preheat) at the next clock edge.
- R3: In any mode, vcc_off_i or sd_hi_i high sets the mode to 0 at the next edge. This wins over every other transition, including a start request in the same cycle.
- R4: Preheat lasts P+1 cycles and is followed by mode 2 (ignition). Ignition lasts I+1 cycles and is followed by mode 3 (run). P and I are the tick values captured in lockout.
- R5: preheat_ticks_i and ignite_ticks_i are sampled only while in lockout. Changing them in any other mode does not alter the current start sequence.
- R6: In preheat and ignition, a low-side on interval (a run of lo_on_i high cycles) in which oc_i is seen high counts as one event. oc_i while lo_on_i is low is ignored. The mode becomes 4 (fault) one edge after the 25th consecutive event has been registered.
- R7: A low-side on interval that ends without oc_i clears the event count.
- R8: The count carries over from preheat into ignition. It is cleared in every other mode, so a restart begins from zero.
- R9: In run, oc_i or eol_bad_i high moves the mode to 4 at the next edge. eol_bad_i has no effect in preheat or ignition.
- R10: Fault holds osc_en_o and pfc_en_o low and persists until vcc_off_i or sd_hi_i.
- R11: In run, bus_uv_i high sets vcc_dump_o at the next edge. The request holds until vcc_off_i or sd_hi_i, and then clears together with the return to lockout. bus_uv_i in any other mode is ignored.
- R12: osc_en_o and pfc_en_o are high exactly in modes 1, 2 and 3 while vcc_dump_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_off_i | input | 1 | Supply below turn-off level |
| sd_hi_i | input | 1 | Shutdown input above its reset level |
| eol_bad_i | input | 1 | End-of-life sense outside its window |
| oc_i | input | 1 | Half-bridge over-current comparator |
| lo_on_i | input | 1 | Low-side switch on-time strobe |
| bus_uv_i | input | 1 | DC bus below under-voltage level |
| preheat_ticks_i | input | TMR_W | Preheat duration in cycles, captured in lockout |
| ignite_ticks_i | input | TMR_W | Ignition duration in cycles, captured in lockout |
| mode_o | output | 3 | 0 lockout, 1 preheat, 2 ignition, 3 run, 4 fault |
| osc_en_o | output | 1 | Half-bridge oscillator enable |
| pfc_en_o | output | 1 | Power-factor stage enable |
| vcc_dump_o | output | 1 | Request to discharge the supply to turn-off |

## Verification
A wrong timer value shows up within one cycle as a mode change that comes early or late, so each mode's length is compared edge by edge. A wrong over-current count stays hidden until the 25th event, when the fault comes one interval early or late, or never comes. For this reason the runs deliberately break the sequence of events and carry it across the preheat-to-ignition boundary. A stuck dump or fault flag shows up at once in the enables, and is checked on every cycle against a behavioural model.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;

    typedef enum logic [2:0] {
        MODE_LOCK    = 3'd0,
        MODE_PREHEAT = 3'd1,
        MODE_IGNITE  = 3'd2,
        MODE_RUN     = 3'd3,
        MODE_FAULT   = 3'd4
    } mode_e;

    typedef struct packed {
        logic vcc_on;
        logic vcc_off;
        logic sd_hi;
        logic eol_bad;
        logic oc;
        logic bus_uv;
    } sense_t;

    localparam int unsigned NUM_PHASE_TMR = 2;

    function automatic logic mode_drives(mode_e m);
        return (m == MODE_PREHEAT) || (m == MODE_IGNITE) || (m == MODE_RUN);
    endfunction

    function automatic logic mode_counts_oc(mode_e m);
        return (m == MODE_PREHEAT) || (m == MODE_IGNITE);
    endfunction

endpackage

// File: rtl/ballast_phase_timer.sv
module ballast_phase_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         clear,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !clear && done) |=> done) else $error("timer wrapped"); // R4

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !load && !clear) |=> $stable(cnt_q)) else $error("idle timer moved"); // R5

endmodule

// File: rtl/ballast_oc_counter.sv
module ballast_oc_counter #(
    parameter int unsigned LIMIT = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lo_on,
    input  logic oc,
    output logic trip
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          hit_q;
    logic          lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= 1'b0;
        end else begin
            lo_q <= lo_on;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else if (lo_on && oc && !hit_q) begin
            if (cnt_q != CW'(LIMIT)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            hit_q <= 1'b1;
        end else if (lo_q && !lo_on) begin
            hit_q <= 1'b0;
            if (!hit_q) begin
                cnt_q <= '0;
            end
        end
    end

    assign trip = (cnt_q == CW'(LIMIT));

    AST_OC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LIMIT)) else $error("count beyond limit"); // R6

    AST_OC_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0)) else $error("count alive outside counting modes"); // R8

    AST_OC_ONE_PER_INTERVAL: assert property (@(posedge clk) disable iff (rst)
        (en && hit_q && lo_on) |=> $stable(cnt_q) || !en) else $error("double count"); // R6

endmodule

// File: rtl/ballast_mode_fsm.sv
module ballast_mode_fsm
    import ballast_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_t sense,
    input  logic   pre_done,
    input  logic   ign_done,
    input  logic   oc_trip,
    output mode_e  mode,
    output logic   dump
);
    mode_e mode_q, mode_d;
    logic  dump_q, dump_d;
    logic  lock_req;

    assign lock_req = sense.vcc_off || sense.sd_hi;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LOCK:    if (sense.vcc_on) mode_d = MODE_PREHEAT;
            MODE_PREHEAT: if (oc_trip) mode_d = MODE_FAULT;
                          else if (pre_done) mode_d = MODE_IGNITE;
            MODE_IGNITE:  if (oc_trip) mode_d = MODE_FAULT;
                          else if (ign_done) mode_d = MODE_RUN;
            MODE_RUN:     if (sense.oc || sense.eol_bad) mode_d = MODE_FAULT;
            MODE_FAULT:   mode_d = MODE_FAULT;
            default:      mode_d = MODE_LOCK;
        endcase
        if (lock_req) begin
            mode_d = MODE_LOCK;
        end
    end

    always_comb begin
        dump_d = dump_q;
        if (lock_req) begin
            dump_d = 1'b0;
        end else if ((mode_q == MODE_RUN) && sense.bus_uv) begin
            dump_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_LOCK;
            dump_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            dump_q <= dump_d;
        end
    end

    assign mode = mode_q;
    assign dump = dump_q;

    AST_LOCK_WINS: assert property (@(posedge clk) disable iff (rst)
        (sense.vcc_off || sense.sd_hi) |=> (mode_q == MODE_LOCK)) else $error("lockout ignored"); // R3

    AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_FAULT) && !sense.vcc_off && !sense.sd_hi) |=> (mode_q == MODE_FAULT))
        else $error("fault left early"); // R10

    AST_PREHEAT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ((mode_q != MODE_PREHEAT) ##1 (mode_q == MODE_PREHEAT)) |-> ($past(mode_q) == MODE_LOCK))
        else $error("preheat not from lockout"); // R2

    AST_DUMP_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(dump_q) |-> ($past(mode_q) == MODE_RUN)) else $error("dump outside run"); // R11

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
    import ballast_seq_pkg::*;
#(
    parameter int unsigned TMR_W    = 16,
    parameter int unsigned OC_LIMIT = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vcc_on_i,
    input  logic             vcc_off_i,
    input  logic             sd_hi_i,
    input  logic             eol_bad_i,
    input  logic             oc_i,
    input  logic             lo_on_i,
    input  logic             bus_uv_i,
    input  logic [TMR_W-1:0] preheat_ticks_i,
    input  logic [TMR_W-1:0] ignite_ticks_i,
    output logic [2:0]       mode_o,
    output logic             osc_en_o,
    output logic             pfc_en_o,
    output logic             vcc_dump_o
);
    sense_t     sense;
    mode_e      mode;
    logic       dump;
    logic       oc_trip;
    logic [TMR_W-1:0] tick_val [NUM_PHASE_TMR];
    logic [NUM_PHASE_TMR-1:0] tmr_done;
    mode_e      tmr_mode [NUM_PHASE_TMR];

    assign sense = '{vcc_on: vcc_on_i, vcc_off: vcc_off_i, sd_hi: sd_hi_i,
                     eol_bad: eol_bad_i, oc: oc_i, bus_uv: bus_uv_i};

    assign tick_val[0] = preheat_ticks_i;
    assign tick_val[1] = ignite_ticks_i;
    assign tmr_mode[0] = MODE_PREHEAT;
    assign tmr_mode[1] = MODE_IGNITE;

    for (genvar g = 0; g < NUM_PHASE_TMR; g++) begin : g_phase
        ballast_phase_timer #(.W(TMR_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (mode == MODE_LOCK),
            .load_val (tick_val[g]),
            .run      (mode == tmr_mode[g]),
            .clear    (mode == MODE_FAULT),
            .done     (tmr_done[g])
        );
    end

    ballast_oc_counter #(.LIMIT(OC_LIMIT)) u_oc (
        .clk   (clk),
        .rst   (rst),
        .en    (mode_counts_oc(mode)),
        .lo_on (lo_on_i),
        .oc    (oc_i),
        .trip  (oc_trip)
    );

    ballast_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sense    (sense),
        .pre_done (tmr_done[0]),
        .ign_done (tmr_done[1]),
        .oc_trip  (oc_trip),
        .mode     (mode),
        .dump     (dump)
    );

    assign mode_o     = mode;
    assign osc_en_o   = mode_drives(mode) && !dump;
    assign pfc_en_o   = mode_drives(mode) && !dump;
    assign vcc_dump_o = dump;

    AST_GATES_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 3'd0) || (mode_o == 3'd4)) |-> (!osc_en_o && !pfc_en_o))
        else $error("gates active while idle"); // R10

    AST_DUMP_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        vcc_dump_o |-> (!osc_en_o && !pfc_en_o)) else $error("gates active during dump"); // R12

    AST_RUN_ONLY_AFTER_IGNITE: assert property (@(posedge clk) disable iff (rst)
        ((mode_o != 3'd3) ##1 (mode_o == 3'd3)) |-> ($past(mode_o) == 3'd2))
        else $error("run not from ignition"); // R4

endmodule

// File: tb/ballast_seq_tb.sv
module ballast_seq_tb;
    localparam int TW  = 16;
    localparam int LIM = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_on = 0, vcc_off = 0, sd_hi = 0, eol_bad = 0, oc = 0, lo_on = 0, bus_uv = 0;
    logic [TW-1:0] pre_t = 16'd3, ign_t = 16'd5;
    logic [2:0] mode_o;
    logic osc_en_o, pfc_en_o, vcc_dump_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    int m_state = 0, m_pre = 0, m_ign = 0, m_cnt = 0;
    bit m_hit = 0, m_loq = 0, m_dump = 0;

    always #5 clk = ~clk;

    ballast_seq #(.TMR_W(TW), .OC_LIMIT(LIM)) u_dut (
        .clk(clk), .rst(rst), .vcc_on_i(vcc_on), .vcc_off_i(vcc_off), .sd_hi_i(sd_hi),
        .eol_bad_i(eol_bad), .oc_i(oc), .lo_on_i(lo_on), .bus_uv_i(bus_uv),
        .preheat_ticks_i(pre_t), .ignite_ticks_i(ign_t), .mode_o(mode_o),
        .osc_en_o(osc_en_o), .pfc_en_o(pfc_en_o), .vcc_dump_o(vcc_dump_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge and compared 2 ns later
    always @(posedge clk) begin
        int ns, np, ni, nc;
        bit nh, nd, lockr, trip, cnt_en, exp_en;
        if (rst) begin
            m_state = 0; m_pre = 0; m_ign = 0; m_cnt = 0; m_hit = 0; m_loq = 0; m_dump = 0;
        end else begin
            lockr  = vcc_off || sd_hi;
            trip   = (m_cnt == LIM);
            cnt_en = (m_state == 1) || (m_state == 2);
            ns = m_state;
            case (m_state)
                0: if (vcc_on) ns = 1;
                1: if (trip) ns = 4; else if (m_pre == 0) ns = 2;
                2: if (trip) ns = 4; else if (m_ign == 0) ns = 3;
                3: if (oc || eol_bad) ns = 4;
                default: ns = m_state;
            endcase
            if (lockr) ns = 0;
            np = (m_state == 0) ? int'(pre_t) : (m_state == 4) ? 0 :
                 ((m_state == 1) && (m_pre > 0)) ? m_pre - 1 : m_pre;
            ni = (m_state == 0) ? int'(ign_t) : (m_state == 4) ? 0 :
                 ((m_state == 2) && (m_ign > 0)) ? m_ign - 1 : m_ign;
            nc = m_cnt; nh = m_hit;
            if (!cnt_en) begin
                nc = 0; nh = 0;
            end else if (lo_on && oc && !m_hit) begin
                if (nc < LIM) nc++;
                nh = 1;
            end else if (m_loq && !lo_on) begin
                nh = 0;
                if (!m_hit) nc = 0;
            end
            nd = lockr ? 1'b0 : ((m_state == 3) && bus_uv) ? 1'b1 : m_dump;
            m_state = ns; m_pre = np; m_ign = ni; m_cnt = nc; m_hit = nh; m_dump = nd;
            m_loq = lo_on;
        end
        #2;
        exp_en = (m_state >= 1) && (m_state <= 3) && !m_dump;
        chk(cur_req, "mode", int'(mode_o), m_state);
        chk((cur_req == "R1") ? "R1" : "R12", "osc_en", int'(osc_en_o), int'(exp_en));
        chk((cur_req == "R1") ? "R1" : "R12", "pfc_en", int'(pfc_en_o), int'(exp_en));
        chk((cur_req == "R1") ? "R1" : "R11", "dump", int'(vcc_dump_o), int'(m_dump));
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic lo_pulse(input bit with_oc);
        @(negedge clk); lo_on = 1; oc = with_oc;
        @(negedge clk); oc = 0;
        @(negedge clk); lo_on = 0;
        cyc(1);
    endtask

    task automatic wait_mode(input int m);
        while (int'(mode_o) != m) @(negedge clk);
    endtask

    task automatic restart(input int p, input int i);
        @(negedge clk); vcc_on = 0; vcc_off = 1;
        pre_t = TW'(p); ign_t = TW'(i);
        @(negedge clk); vcc_off = 0; vcc_on = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1", "mode in reset", int'(mode_o), 0);
        rst = 0;
        cyc(1);
        chk("R1", "dump after reset", int'(vcc_dump_o), 0);

        // R2 / R4 / R5: normal start, tick inputs changed mid-sequence
        cur_req = "R2";
        vcc_on = 1;
        cyc(2);
        chk("R2", "preheat entered", int'(mode_o), 1);
        cur_req = "R5";
        pre_t = 16'd40; ign_t = 16'd60;
        cur_req = "R4";
        cyc(3);
        chk("R4", "ignition after P+1", int'(mode_o), 2);
        cur_req = "R9";
        eol_bad = 1; cyc(2); eol_bad = 0;
        chk("R9", "eol ignored in ignition", int'(mode_o), 2);
        cur_req = "R5";
        cyc(4);
        chk("R5", "run after captured I", int'(mode_o), 3);

        // R9 / R10: end-of-life in run, fault latched
        cur_req = "R9";
        eol_bad = 1; cyc(1); eol_bad = 0;
        chk("R9", "fault on eol in run", int'(mode_o), 4);
        cur_req = "R10";
        cyc(10);
        chk("R10", "fault held", int'(mode_o), 4);
        chk("R10", "osc off in fault", int'(osc_en_o), 0);

        // R3: shutdown releases, blocks start, precedence
        cur_req = "R3";
        sd_hi = 1; cyc(3);
        chk("R3", "lockout on shutdown", int'(mode_o), 0);
        sd_hi = 0; vcc_off = 1; cyc(3);
        chk("R3", "turn-off wins over start", int'(mode_o), 0);

        // R6 / R7: over-current counting in preheat
        pre_t = 16'd300; ign_t = 16'd300;
        cyc(1); vcc_off = 0;
        cur_req = "R6";
        cyc(2);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); oc = 1; @(negedge clk); oc = 0;
        end
        cur_req = "R7";
        for (int k = 0; k < 10; k++) lo_pulse(1);
        lo_pulse(0);
        for (int k = 0; k < 24; k++) lo_pulse(1);
        cyc(2);
        chk("R7", "cleared by clean interval", int'(mode_o), 1);
        cur_req = "R6";
        lo_pulse(1);
        cyc(2);
        chk("R6", "fault after 25 consecutive", int'(mode_o), 4);

        // R8: count carries from preheat into ignition, cleared on restart
        cur_req = "R8";
        restart(90, 300);
        for (int k = 0; k < 20; k++) lo_pulse(1);
        wait_mode(2);
        for (int k = 0; k < 4; k++) lo_pulse(1);
        cyc(2);
        chk("R8", "24 events no fault", int'(mode_o), 2);
        lo_pulse(1);
        cyc(2);
        chk("R8", "fault across boundary", int'(mode_o), 4);
        restart(200, 10);
        for (int k = 0; k < 24; k++) lo_pulse(1);
        cyc(2);
        chk("R8", "fresh count after restart", int'(mode_o), 1);

        // R11: bus under-voltage ignored outside run, dump in run
        cur_req = "R11";
        restart(3, 3);
        cyc(2);
        bus_uv = 1; cyc(2); bus_uv = 0;
        chk("R11", "no dump in preheat", int'(vcc_dump_o), 0);
        wait_mode(3);
        bus_uv = 1; cyc(1); bus_uv = 0;
        chk("R11", "dump in run", int'(vcc_dump_o), 1);
        cyc(5);
        chk("R12", "gates off while dumping", int'(pfc_en_o), 0);
        vcc_off = 1; cyc(1);
        chk("R11", "dump cleared with lockout", int'(vcc_dump_o), 0);

        // R9: single over-current in run, outside low-side on
        cur_req = "R9";
        restart(2, 2);
        wait_mode(3);
        cyc(2);
        oc = 1; cyc(1); oc = 0;
        chk("R9", "single oc faults run", int'(mode_o), 4);
        cyc(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule